// File: doc/BRIEF.md
# Half-Rate Pixel Clock Phase and Pixel Capture Control

This block sits at the input of a video encoder that runs from a master clock at twice the pixel rate. It produces a one-cycle-wide pixel clock enable (`pck_en`) that is high on every other master clock cycle. The phase of that enable is fixed by one of three sources, chosen by the operating mode. In the self-timed mode the phase comes from the release of the hardware reset. In the follower mode it comes from the horizontal sync input. In the locked mode it comes from the genlock sync input. In the self-timed mode the block also produces its own horizontal and vertical sync outputs, which advance on the enabled cycles.

The block also takes 24-bit pixels from an external source. A rising edge on the load strobe stores the word into three 8-bit lane registers. The stored word is then handed to the pipeline output on the next enabled pixel-clock cycle. A small control register holds the mode and a run bit. The hardware reset clears the run bit and keeps the mode. While the run bit is low, the pixel output is held at zero.

Top module: `pixclk_phase_ctrl`

## Requirements
- R1: `pck_en` changes value on every master clock edge after reset, except on an alignment edge (R4, R5).
- R2: An edge with `rst` high drives `pck_en`, `pix_vld`, `hsync_out`, `vsync_out` and `pix_out` to zero, and restarts the sync timing at pixel 0 of line 0.
- R3: In the self-timed mode (mode 2'b00), the first edge with `rst` sampled low after a reset sets `pck_en` high. After that, `pck_en` is high following the odd-numbered edges counted from the release.
- R4: In the follower mode (mode 2'b01), an edge that sees `vhsync_in` high after it was low one cycle earlier sets `pck_en` high. `ghsync_in` has no effect on the phase in this mode.
- R5: In the locked mode (mode 2'b10), an edge that sees a rising `ghsync_in` sets `pck_en` high. `vhsync_in` has no effect on the phase in this mode.
- R6: In the self-timed mode, `hsync_out` and `vsync_out` change only on edges where `pck_en` was high, which are the pixel-clock rising edges.
- R7: `hsync_out` is high for the first HS_PCKS pixel clocks of each LINE_PCKS-pixel line. The line count starts at the first pixel-clock edge after reset. In the follower and locked modes, both sync outputs are held low.
- R8: `vsync_out` is high during the first VS_LINES lines of each FRAME_LINES-line frame.
- R9: A rising edge of `ldv` stores `pix_in` into three lanes, with lane k taking bits 8k+7:8k. The stored word appears on `pix_out`, at the same bit positions, on the next edge after the capture edge where `pck_en` was high. `pix_vld` is high for one cycle at that point. Otherwise `pix_out` holds its value.
- R10: While the run bit (`srst_bit`) is low, `pix_out` is driven to zero and `pix_vld` stays low.
- R11: `ctl_we` loads `ctl_mode` and `ctl_run` into the control register. `rst` clears the run bit, even when a write to it is made in the same cycle. `rst` leaves the stored mode unchanged.
- R12: Mode 2'b11 behaves exactly as the self-timed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the pixel rate |
| rst | input | 1 | Hardware reset, synchronous, active high |
| ctl_we | input | 1 | Control register write strobe |
| ctl_mode | input | 2 | Mode value to write (00 self-timed, 01 follower, 10 locked, 11 self-timed) |
| ctl_run | input | 1 | Run bit value to write |
| vhsync_in | input | 1 | Horizontal sync input, sets the phase in the follower mode |
| ghsync_in | input | 1 | Genlock sync input, sets the phase in the locked mode |
| ldv | input | 1 | Pixel load strobe, acts on its rising edge |
| pix_in | input | 24 | Pixel word to load |
| pck_en | output | 1 | Pixel clock enable, high on alternate cycles |
| pix_out | output | 24 | Pixel word handed to the pipeline |
| pix_vld | output | 1 | One-cycle pulse when `pix_out` takes a new word |
| srst_bit | output | 1 | Current run bit of the control register |
| hsync_out | output | 1 | Generated horizontal sync (self-timed mode) |
| vsync_out | output | 1 | Generated vertical sync (self-timed mode) |

## Verification
The phase logic is driven with sync pulses that arrive while the enable is already high. Only a true realignment makes the enable stay high on such an edge, so these pulses separate realignment from plain toggling. The same pulses are also sent on the sync input of the other mode, to confirm that input is ignored. Load strobes arrive at random spacing, including on the same cycle as an enable and back to back before a transfer. This shows whether the newest word wins and whether the hand-off waits for the next enabled edge. Resets are applied in the middle of a run in the follower mode. This shows whether the run bit clears while the mode survives.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

  typedef enum logic [1:0] {
    MODE_SELF   = 2'b00,
    MODE_FOLLOW = 2'b01,
    MODE_LOCK   = 2'b10,
    MODE_ALT    = 2'b11
  } pcp_mode_e;

  function automatic logic mode_is_self(input logic [1:0] m);
    return (m == MODE_SELF) || (m == MODE_ALT);
  endfunction

endpackage

// File: rtl/pcp_ctl_reg.sv
module pcp_ctl_reg
  import pcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] wr_mode,
  input  logic       wr_run,
  output logic [1:0] mode_q,
  output logic       run_q
);

  logic [1:0] mode_r = 2'b00;
  logic       run_r  = 1'b0;

  // the mode survives the hardware reset, so it carries no reset term
  always_ff @(posedge clk) begin
    if (we) mode_r <= wr_mode;
  end

  always_ff @(posedge clk) begin
    if (rst)     run_r <= 1'b0;
    else if (we) run_r <= wr_run;
  end

  assign mode_q = mode_r;
  assign run_q  = run_r;

  p_run_cleared_r11: assert property (@(posedge clk) rst |=> !run_r)
    else $error("run bit not cleared by reset");
  p_mode_kept_r11: assert property (@(posedge clk) (rst && !we) |=> $stable(mode_r))
    else $error("mode changed across reset");

endmodule

// File: rtl/pcp_phase_gen.sv
module pcp_phase_gen
  import pcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       vhsync,
  input  logic       ghsync,
  output logic       pck_en
);

  logic vh_d = 1'b0;
  logic gh_d = 1'b0;
  logic pck_q;
  logic vh_rise, gh_rise, align;

  always_ff @(posedge clk) begin
    vh_d <= vhsync;
    gh_d <= ghsync;
  end

  assign vh_rise = vhsync & ~vh_d;
  assign gh_rise = ghsync & ~gh_d;
  assign align   = ((mode == MODE_FOLLOW) && vh_rise) ||
                   ((mode == MODE_LOCK)   && gh_rise);

  always_ff @(posedge clk) begin
    if (rst)        pck_q <= 1'b0;
    else if (align) pck_q <= 1'b1;
    else            pck_q <= ~pck_q;
  end

  assign pck_en = pck_q;

  p_alternate_r1: assert property (@(posedge clk) disable iff (rst)
    !align |=> (pck_q != $past(pck_q)))
    else $error("enable did not alternate");
  p_reset_low_r2: assert property (@(posedge clk) rst |=> !pck_q)
    else $error("enable high after reset edge");
  p_self_start_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && mode_is_self(mode)) |=> pck_q)
    else $error("self-timed phase not set by release");
  p_follow_align_r4: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_FOLLOW) && vhsync && !vh_d) |=> pck_q)
    else $error("follower phase not aligned");
  p_lock_align_r5: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_LOCK) && ghsync && !gh_d) |=> pck_q)
    else $error("locked phase not aligned");

endmodule

// File: rtl/pcp_sync_gen.sv
module pcp_sync_gen #(
  parameter int LINE_PCKS   = 858,
  parameter int HS_PCKS     = 64,
  parameter int FRAME_LINES = 525,
  parameter int VS_LINES    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic self_mode,
  input  logic pck_en,
  output logic hsync,
  output logic vsync
);

  localparam int CNT_W = (LINE_PCKS > 1) ? $clog2(LINE_PCKS) : 1;
  localparam int LN_W  = (FRAME_LINES > 1) ? $clog2(FRAME_LINES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_PCKS - 1);
  localparam logic [LN_W-1:0]  LN_LAST  = LN_W'(FRAME_LINES - 1);
  localparam logic [CNT_W-1:0] HS_END   = CNT_W'(HS_PCKS);
  localparam logic [LN_W-1:0]  VS_END   = LN_W'(VS_LINES);

  logic [CNT_W-1:0] pix_cnt;
  logic [LN_W-1:0]  line_cnt;
  logic             hs_q, vs_q;

  always_ff @(posedge clk) begin
    if (rst || !self_mode) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
    end else if (pck_en) begin
      hs_q <= (pix_cnt < HS_END);
      vs_q <= (line_cnt < VS_END);
      if (pix_cnt == CNT_LAST) begin
        pix_cnt  <= '0;
        line_cnt <= (line_cnt == LN_LAST) ? '0 : line_cnt + 1'b1;
      end else begin
        pix_cnt <= pix_cnt + 1'b1;
      end
    end
  end

  assign hsync = hs_q;
  assign vsync = vs_q;

  p_pck_edge_only_r6: assert property (@(posedge clk) disable iff (rst)
    (self_mode && !pck_en) |=> ($stable(hs_q) && $stable(vs_q)))
    else $error("sync moved off a pixel clock edge");
  p_quiet_other_r7: assert property (@(posedge clk) disable iff (rst)
    !self_mode |=> (!hs_q && !vs_q))
    else $error("sync active outside self-timed mode");
  p_sync_reset_r2: assert property (@(posedge clk) rst |=> (!hs_q && !vs_q))
    else $error("sync high after reset edge");

endmodule

// File: rtl/pcp_pix_cap.sv
module pcp_pix_cap #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  localparam int PIX_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pck_en,
  input  logic             ldv,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_out,
  output logic             pix_vld
);

  logic             ldv_d = 1'b0;
  logic             ldv_rise;
  logic             pend_q;
  logic             xfer;
  logic [PIX_W-1:0] cap_word;
  logic [PIX_W-1:0] out_q;
  logic             vld_q;

  always_ff @(posedge clk) ldv_d <= ldv;
  assign ldv_rise = ldv & ~ldv_d;
  assign xfer     = pck_en & pend_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] lane_q = '0;
    always_ff @(posedge clk) begin
      if (ldv_rise) lane_q <= pix_in[k*LANE_W +: LANE_W];
    end
    assign cap_word[k*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= ldv_rise | (pend_q & ~pck_en);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else if (xfer) begin
      out_q <= cap_word;
      vld_q <= 1'b1;
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign pix_out = out_q;
  assign pix_vld = vld_q;

  p_zero_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> ((out_q == '0) && !vld_q))
    else $error("pixel not zero while run bit low");
  p_vld_on_pck_r9: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> $past(pck_en))
    else $error("pixel handed over off a pixel clock edge");
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !pck_en) |=> $stable(out_q))
    else $error("pixel output changed without transfer");
  p_pix_reset_r2: assert property (@(posedge clk) rst |=> ((out_q == '0) && !vld_q))
    else $error("pixel output not cleared by reset");

endmodule

// File: rtl/pixclk_phase_ctrl.sv
module pixclk_phase_ctrl
  import pcp_pkg::*;
#(
  parameter int LANES       = 3,
  parameter int LANE_W      = 8,
  parameter int LINE_PCKS   = 858,
  parameter int HS_PCKS     = 64,
  parameter int FRAME_LINES = 525,
  parameter int VS_LINES    = 3,
  localparam int PIX_W      = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_mode,
  input  logic             ctl_run,
  input  logic             vhsync_in,
  input  logic             ghsync_in,
  input  logic             ldv,
  input  logic [PIX_W-1:0] pix_in,
  output logic             pck_en,
  output logic [PIX_W-1:0] pix_out,
  output logic             pix_vld,
  output logic             srst_bit,
  output logic             hsync_out,
  output logic             vsync_out
);

  logic [1:0] mode_q;
  logic       run_q;
  logic       pck_q;

  pcp_ctl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .we      (ctl_we),
    .wr_mode (ctl_mode),
    .wr_run  (ctl_run),
    .mode_q  (mode_q),
    .run_q   (run_q)
  );

  pcp_phase_gen u_phase (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_q),
    .vhsync (vhsync_in),
    .ghsync (ghsync_in),
    .pck_en (pck_q)
  );

  pcp_sync_gen #(
    .LINE_PCKS   (LINE_PCKS),
    .HS_PCKS     (HS_PCKS),
    .FRAME_LINES (FRAME_LINES),
    .VS_LINES    (VS_LINES)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .self_mode (mode_is_self(mode_q)),
    .pck_en    (pck_q),
    .hsync     (hsync_out),
    .vsync     (vsync_out)
  );

  pcp_pix_cap #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_pix (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .pck_en  (pck_q),
    .ldv     (ldv),
    .pix_in  (pix_in),
    .pix_out (pix_out),
    .pix_vld (pix_vld)
  );

  assign pck_en   = pck_q;
  assign srst_bit = run_q;

endmodule

// File: tb/pixclk_phase_ctrl_tb.sv
module pixclk_phase_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LP = 10;
  localparam int HP = 2;
  localparam int FL = 4;
  localparam int VL = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_mode = 2'b00;
  logic        ctl_run = 1'b0;
  logic        vhsync_in = 1'b0;
  logic        ghsync_in = 1'b0;
  logic        ldv = 1'b0;
  logic [23:0] pix_in = '0;
  logic        pck_en, pix_vld, srst_bit, hsync_out, vsync_out;
  logic [23:0] pix_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixclk_phase_ctrl #(.LINE_PCKS(LP), .HS_PCKS(HP), .FRAME_LINES(FL), .VS_LINES(VL)) u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_mode(ctl_mode), .ctl_run(ctl_run),
    .vhsync_in(vhsync_in), .ghsync_in(ghsync_in), .ldv(ldv), .pix_in(pix_in),
    .pck_en(pck_en), .pix_out(pix_out), .pix_vld(pix_vld), .srst_bit(srst_bit),
    .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // expected-state model built from the requirements
  logic        m_pck = 0, m_run = 0, m_hs = 0, m_vs = 0, m_vld = 0, m_pend = 0;
  logic [1:0]  m_mode = 0;
  int          m_cnt = 0, m_line = 0;
  logic [23:0] m_pix = 0, m_cap = 0;
  logic        m_vh_d = 0, m_gh_d = 0, m_ldv_d = 0;

  function automatic bit self_mode(input logic [1:0] m);
    return (m == 2'b00) || (m == 2'b11);
  endfunction

  task automatic model_edge();
    logic old, align, rise;
    rise = ldv & ~m_ldv_d;
    if (rst) begin
      m_pck = 0; m_cnt = 0; m_line = 0; m_hs = 0; m_vs = 0;
      m_pix = 0; m_vld = 0; m_pend = 0; m_run = 0;
    end else begin
      align = ((m_mode == 2'b01) && vhsync_in && !m_vh_d) ||
              ((m_mode == 2'b10) && ghsync_in && !m_gh_d);
      old = m_pck;
      m_pck = align ? 1'b1 : ~m_pck;
      if (!self_mode(m_mode)) begin
        m_cnt = 0; m_line = 0; m_hs = 0; m_vs = 0;
      end else if (old) begin
        m_hs = (m_cnt < HP);
        m_vs = (m_line < VL);
        if (m_cnt == LP - 1) begin
          m_cnt = 0;
          m_line = (m_line == FL - 1) ? 0 : m_line + 1;
        end else m_cnt = m_cnt + 1;
      end
      if (!m_run) begin m_pix = 0; m_vld = 0; end
      else if (old && m_pend) begin m_pix = m_cap; m_vld = 1; end
      else m_vld = 0;
      m_pend = rise | (m_pend & ~old);
      if (ctl_we) m_run = ctl_run;
    end
    if (rise) m_cap = pix_in;
    if (ctl_we) m_mode = ctl_mode;
    m_vh_d = vhsync_in; m_gh_d = ghsync_in; m_ldv_d = ldv;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    check("R1", "pck_en", 32'(pck_en), 32'(m_pck));
    check("R7", "hsync_out", 32'(hsync_out), 32'(m_hs));
    check("R8", "vsync_out", 32'(vsync_out), 32'(m_vs));
    check("R9", "pix_out", 32'(pix_out), 32'(m_pix));
    check("R9", "pix_vld", 32'(pix_vld), 32'(m_vld));
    check("R11", "srst_bit", 32'(srst_bit), 32'(m_run));
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    #2;
    compare_all();
    ctl_we = 0;
  endtask

  task automatic write_ctl(input logic [1:0] m, input logic r);
    ctl_we = 1; ctl_mode = m; ctl_run = r;
    step();
  endtask

  task automatic random_run(input int n, input bit use_vh, input bit use_gh);
    for (int i = 0; i < n; i++) begin
      if (($urandom % 5) == 0) begin ldv = ~ldv; pix_in = 24'($urandom); end
      if (use_vh) vhsync_in = (($urandom % 7) == 0);
      if (use_gh) ghsync_in = (($urandom % 7) == 0);
      step();
    end
    vhsync_in = 0; ghsync_in = 0; ldv = 0;
    step();
  endtask

  task automatic wait_pck_high();
    for (int i = 0; i < 4 && !m_pck; i++) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    // reset with a run write that must not take effect
    ctl_we = 1; ctl_mode = 2'b00; ctl_run = 1;
    step(); step(); step();
    check("R2", "pck_en in reset", 32'(pck_en), 0);
    check("R2", "pix_out in reset", 32'(pix_out), 0);
    check("R11", "run write during reset", 32'(srst_bit), 0);

    // R3: release in self-timed mode
    rst = 0;
    step();
    check("R3", "pck_en after first edge", 32'(pck_en), 1);
    step();
    check("R6", "hsync at second edge", 32'(hsync_out), 1);
    write_ctl(2'b00, 1);
    random_run(400, 1, 1);

    // R10: run low keeps pixel at zero
    write_ctl(2'b00, 0);
    ldv = 1; pix_in = 24'hA5C3F0;
    for (int i = 0; i < 6; i++) step();
    ldv = 0;
    check("R10", "pix_out with run low", 32'(pix_out), 0);
    check("R10", "pix_vld with run low", 32'(pix_vld), 0);

    // R9: directed lane placement
    write_ctl(2'b00, 1);
    wait_pck_high();
    ldv = 1; pix_in = 24'h123456;
    step();
    ldv = 0;
    step(); step(); step();
    check("R9", "lane order", 32'(pix_out), 32'h123456);

    // R4: follower mode
    write_ctl(2'b01, 1);
    wait_pck_high();
    vhsync_in = 1;
    step();
    check("R4", "aligned on vhsync", 32'(pck_en), 1);
    vhsync_in = 0; step();
    wait_pck_high();
    ghsync_in = 1; step();
    check("R4", "ghsync ignored", 32'(pck_en), 0);
    ghsync_in = 0;
    random_run(300, 1, 1);

    // R11: reset mid-run keeps follower mode
    rst = 1; step(); step();
    check("R11", "run cleared", 32'(srst_bit), 0);
    check("R7", "sync low outside self-timed", 32'(hsync_out), 0);
    rst = 0; step();
    wait_pck_high();
    vhsync_in = 1; step();
    check("R11", "mode kept after reset", 32'(pck_en), 1);
    vhsync_in = 0; step();

    // R5: locked mode
    write_ctl(2'b10, 1);
    wait_pck_high();
    ghsync_in = 1; step();
    check("R5", "aligned on ghsync", 32'(pck_en), 1);
    ghsync_in = 0; step();
    wait_pck_high();
    vhsync_in = 1; step();
    check("R5", "vhsync ignored", 32'(pck_en), 0);
    vhsync_in = 0;
    random_run(300, 1, 1);

    // R12: alternate code behaves as self-timed
    write_ctl(2'b11, 1);
    rst = 1; step(); rst = 0; step();
    check("R12", "pck_en after release", 32'(pck_en), 1);
    step();
    check("R12", "hsync generated", 32'(hsync_out), 1);
    random_run(300, 0, 0);

    finish_run();
  end

endmodule